// File: doc/BRIEF.md
# Quadrature Encoder Decoder with Selectable Resolution

This block sits between the two phase pins of an incremental encoder and a position counter. It turns the phase pins into a one-cycle count strobe and an up/down bit that the counter consumes. Both pins first pass through a two-flop synchronizer. In quadrature operation they then pass through a glitch filter, whose sampling rate comes from a programmable prescaler, and then into a transition decoder.

A two-bit resolution field picks the operating mode. Value 0 bypasses the filter and decoder: phase A acts as a count clock and phase B as a direction level. Values 1, 2 and 3 select quadrature decoding at one, two or four counts per encoder cycle. When both filtered phases change in the same sample, the transition is illegal. The decoder then raises a sticky noise flag, which only a clear strobe removes. A count-enable input gates all counting and error detection. The counter itself is not part of this block.

Top module: `qdec_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `cnt_stb`, `cnt_up` and `noise_err` are 0.
- R2: With `res_mode`=0, each rising edge of `pin_a` gives exactly one `cnt_stb` pulse, with `cnt_up` equal to `pin_b` (1 = up, 0 = down). A falling edge of `pin_a` gives no pulse. `noise_err` is never set in this mode, even when both pins change together.
- R3: In quadrature modes, a new pin level is accepted only after three consecutive prescaled samples have seen it. A pulse shorter than that produces no count.
- R4: The filter samples once every `presc_div`+1 clock cycles.
- R5: With `res_mode`=3 (x4), every legal single-phase transition counts once. Written {A,B}, the sequence 00→10→11→01→00 (A leads B) counts up, and the reverse sequence counts down.
- R6: With `res_mode`=2 (x2), only the transitions that change A count. Direction is as in R5.
- R7: With `res_mode`=1 (x1), only the transitions 00→10 (up) and 10→00 (down) count.
- R8: In a quadrature mode, a simultaneous change of both filtered phases sets `noise_err` and produces no count.
- R9: `noise_err` stays set until `err_clr` is pulsed. After the pulse it reads 0.
- R10: While `count_en` is 0, no `cnt_stb` pulse occurs and `noise_err` is not set. After `count_en` is re-enabled, counting resumes from the current pin state without a spurious count.
- R11: In mode 0, `cnt_stb` is high in the cycle after the third rising clock edge that follows a change of `pin_a`. In x4 mode with `presc_div`=0, it is high after the sixth edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_a | input | 1 | Encoder phase A (count clock in mode 0) |
| pin_b | input | 1 | Encoder phase B (direction level in mode 0) |
| count_en | input | 1 | Enables counting and error detection |
| res_mode | input | 2 | 0 clock/direction, 1 x1, 2 x2, 3 x4 |
| presc_div | input | 8 | Filter sample period minus one, in clocks |
| err_clr | input | 1 | Clears the noise flag |
| cnt_stb | output | 1 | One-cycle count pulse |
| cnt_up | output | 1 | Direction of the last count, 1 = up |
| noise_err | output | 1 | Sticky illegal-transition flag |

## Verification
In mode 0 the strobe is due three edges after a pin change: two synchronizer stages plus the output register. In quadrature mode it is due after the two synchronizer stages, three filter samples spaced `presc_div`+1 clocks apart, and one decode register. The directed latency checks therefore sample at the negative edge one cycle before and exactly at the due cycle. For the random bursts, each pin state is held for at least 4·(`presc_div`+1)+4 cycles, and an extra settling window follows before the bench compares the strobes it has accumulated with the expected position. Error and enable checks are read only after that same settling window.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef enum logic [1:0] {
        RES_NONE = 2'd0,
        RES_X1   = 2'd1,
        RES_X2   = 2'd2,
        RES_X4   = 2'd3
    } res_e;

    typedef struct packed {
        logic a;
        logic b;
    } ab_t;

    localparam int SYNC_DEPTH   = 2;
    localparam int FILT_SAMPLES = 3;

    // Direction of a single-phase step; A leading B is up.
    function automatic logic step_is_up(ab_t prv, ab_t cur);
        logic moved_a;
        moved_a = prv.a ^ cur.a;
        return moved_a ? (cur.a != cur.b) : (cur.a == cur.b);
    endfunction

    // Whether a step produces a count at the selected resolution.
    function automatic logic step_counts(res_e res, ab_t prv, ab_t cur);
        logic moved_a, moved_b;
        moved_a = prv.a ^ cur.a;
        moved_b = prv.b ^ cur.b;
        case (res)
            RES_X4:  return moved_a ^ moved_b;
            RES_X2:  return moved_a & ~moved_b;
            RES_X1:  return moved_a & ~moved_b & ~cur.b;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/qdec_prescaler.sv
module qdec_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] div_cnt;

    assign tick_o = (div_cnt >= div_i);

    always_ff @(posedge clk) begin
        if (rst || tick_o) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst || div_i == '0)
        tick_o |=> !tick_o);

endmodule

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int WIDTH = 2,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [DEPTH-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < DEPTH; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q_o = stg[DEPTH-1];

endmodule

// File: rtl/qdec_filter.sv
module qdec_filter
    import qdec_pkg::*;
#(
    parameter int SAMPLES = FILT_SAMPLES
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  ab_t  raw_i,
    output ab_t  flt_o
);
    localparam int HIST = SAMPLES - 1;

    logic [1:0] raw_v;
    logic [1:0] flt_v;

    assign raw_v = raw_i;
    assign flt_o = flt_v;

    for (genvar ch = 0; ch < 2; ch++) begin : g_phase
        logic [HIST-1:0] hist;
        logic            agree;

        assign agree = raw_v[ch] ? (&hist) : ~(|hist);

        always_ff @(posedge clk) begin
            if (rst) begin
                hist      <= '0;
                flt_v[ch] <= 1'b0;
            end else if (tick_i) begin
                hist[0] <= raw_v[ch];
                for (int i = 1; i < HIST; i++) begin
                    hist[i] <= hist[i-1];
                end
                if (agree) begin
                    flt_v[ch] <= raw_v[ch];
                end
            end
        end
    end

    // R3
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(flt_o));

endmodule

// File: rtl/qdec_decoder.sv
module qdec_decoder
    import qdec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  res_e res_i,
    input  ab_t  syn_i,
    input  ab_t  flt_i,
    input  logic clr_i,
    output logic stb_o,
    output logic up_o,
    output logic err_o
);
    ab_t  flt_d;
    logic nq_a_d;
    logic bypass;
    logic nq_rise;
    logic q_hit, q_up, q_both;
    logic hit, hit_up;

    assign bypass  = (res_i == RES_NONE);
    assign nq_rise = syn_i.a & ~nq_a_d;
    assign q_both  = (flt_i.a ^ flt_d.a) & (flt_i.b ^ flt_d.b);
    assign q_hit   = step_counts(res_i, flt_d, flt_i);
    assign q_up    = step_is_up(flt_d, flt_i);
    assign hit     = en_i & (bypass ? nq_rise : q_hit);
    assign hit_up  = bypass ? syn_i.b : q_up;

    always_ff @(posedge clk) begin
        if (rst) begin
            flt_d  <= '0;
            nq_a_d <= 1'b0;
            stb_o  <= 1'b0;
            up_o   <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            flt_d  <= flt_i;
            nq_a_d <= syn_i.a;
            stb_o  <= hit;
            if (hit) begin
                up_o <= hit_up;
            end
            err_o <= (err_o & ~clr_i) | (en_i & ~bypass & q_both);
        end
    end

    // R2
    bypass_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        (bypass && !err_o) |=> !err_o);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_o && !clr_i) |=> err_o);

    // R10
    en_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !stb_o);

    // R10
    en_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !err_o) |=> !err_o);

endmodule

// File: rtl/qdec_top.sv
module qdec_top
    import qdec_pkg::*;
#(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pin_a,
    input  logic               pin_b,
    input  logic               count_en,
    input  logic [1:0]         res_mode,
    input  logic [PRESC_W-1:0] presc_div,
    input  logic               err_clr,
    output logic               cnt_stb,
    output logic               cnt_up,
    output logic               noise_err
);
    ab_t  pins;
    ab_t  syn;
    ab_t  flt;
    logic tick;
    res_e res;

    assign pins.a = pin_a;
    assign pins.b = pin_b;
    assign res    = res_e'(res_mode);

    qdec_sync #(.WIDTH(2), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pins),
        .q_o (syn)
    );

    qdec_prescaler #(.DIV_W(PRESC_W)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .div_i  (presc_div),
        .tick_o (tick)
    );

    qdec_filter #(.SAMPLES(FILT_SAMPLES)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .raw_i  (syn),
        .flt_o  (flt)
    );

    qdec_decoder u_dec (
        .clk   (clk),
        .rst   (rst),
        .en_i  (count_en),
        .res_i (res),
        .syn_i (syn),
        .flt_i (flt),
        .clr_i (err_clr),
        .stb_o (cnt_stb),
        .up_o  (cnt_up),
        .err_o (noise_err)
    );

endmodule

// File: tb/qdec_top_bench.sv
`timescale 1ns/1ps
module qdec_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_a = 1'b0, pin_b = 1'b0, count_en = 1'b1, err_clr = 1'b0;
    logic [1:0] res_mode = 2'd0;
    logic [7:0] presc_div = 8'd0;
    logic       cnt_stb, cnt_up, noise_err;

    int total = 0, bad = 0;
    int pos = 0, nstb = 0, expq = 0, idx = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    qdec_top u_qdec_top (
        .clk(clk), .rst(rst), .pin_a(pin_a), .pin_b(pin_b),
        .count_en(count_en), .res_mode(res_mode), .presc_div(presc_div),
        .err_clr(err_clr), .cnt_stb(cnt_stb), .cnt_up(cnt_up),
        .noise_err(noise_err)
    );

    always @(posedge clk) begin
        #1;
        if (!rst && cnt_stb) begin
            pos  = pos + (cnt_up ? 1 : -1);
            nstb = nstb + 1;
        end
    end

    task automatic check_eq(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] gray(int i);
        case (i & 3)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    function automatic int step_delta(int m, logic [1:0] f, logic [1:0] t, bit dir);
        int s;
        s = dir ? 1 : -1;
        case (m)
            3: return s;
            2: return (f[1] != t[1]) ? s : 0;
            1: return ((f == 2'b00 && t == 2'b10) || (f == 2'b10 && t == 2'b00)) ? s : 0;
            default: return 0;
        endcase
    endfunction

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ab(logic [1:0] v);
        @(negedge clk);
        pin_a = v[1];
        pin_b = v[0];
    endtask

    task automatic qmove(bit dir);
        int nxt;
        nxt  = dir ? idx + 1 : idx + 3;
        expq += step_delta(res_mode, gray(idx), gray(nxt), dir);
        idx  = nxt & 3;
        set_ab(gray(idx));
        wait_n((presc_div + 1) * 4 + 4);
    endtask

    task automatic run_quad(int m, int p, int steps, string tag);
        @(negedge clk);
        res_mode = m[1:0];
        presc_div = p[7:0];
        wait_n(40);
        pos = 0; expq = 0;
        for (int i = 0; i < steps; i++) begin
            qmove(($urandom % 3) != 0);
        end
        wait_n(40 * (p + 1));
        check_eq(tag, pos, expq);
        check_eq({tag, " no error"}, noise_err, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        wait_n(4);
        // R1
        check_eq("R1 stb in reset", cnt_stb, 0);
        check_eq("R1 err in reset", noise_err, 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 up after reset", cnt_up, 0);

        // R2 / R11 bypass latency
        pin_b = 1'b1;
        wait_n(4);
        pin_a = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_eq("R11 bypass strobe not early", cnt_stb, 0);
        @(posedge clk); @(negedge clk);
        check_eq("R11 bypass strobe due", cnt_stb, 1);
        check_eq("R2 bypass up from B", cnt_up, 1);
        wait_n(4);
        pos = 0;
        pin_a = 1'b0;
        wait_n(6);
        check_eq("R2 falling edge no count", pos, 0);

        // R2 random pulses
        pos = 0; expq = 0;
        for (int i = 0; i < 20; i++) begin
            bit d;
            d = $urandom % 2;
            pin_b = d;
            wait_n(4);
            pin_a = 1'b1;
            wait_n(3 + $urandom % 3);
            pin_a = 1'b0;
            wait_n(3 + $urandom % 3);
            expq += d ? 1 : -1;
        end
        wait_n(6);
        check_eq("R2 bypass pulse count", pos, expq);
        set_ab(2'b11);
        wait_n(6);
        set_ab(2'b00);
        wait_n(6);
        check_eq("R2 no error in bypass", noise_err, 0);

        // R11 quadrature latency, x4, presc 0
        res_mode = 2'd3;
        wait_n(10);
        pos = 0; idx = 0;
        pin_a = 1'b1;
        idx = 1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check_eq("R11 quad strobe not early", cnt_stb, 0);
        @(posedge clk); @(negedge clk);
        check_eq("R11 quad strobe due", cnt_stb, 1);
        check_eq("R5 A leads B is up", cnt_up, 1);
        wait_n(10);

        // R3 glitch rejection
        pos = 0;
        pin_b = 1'b1;
        wait_n(2);
        pin_b = 1'b0;
        wait_n(20);
        check_eq("R3 short pulse ignored", pos, 0);

        // R4 prescaled sampling
        presc_div = 8'd4;
        wait_n(10);
        nstb = 0;
        pin_b = 1'b1;
        wait_n(9);
        pin_b = 1'b0;
        wait_n(60);
        check_eq("R4 9-cycle pulse rejected at div 4", nstb, 0);
        pin_b = 1'b1;
        wait_n(30);
        pin_b = 1'b0;
        wait_n(60);
        check_eq("R4 30-cycle pulse accepted at div 4", nstb, 2);

        // R5 R6 R7 random bursts
        run_quad(3, 0, 40, "R5 x4 div0");
        run_quad(3, 2, 30, "R5 x4 div2");
        run_quad(2, 1, 40, "R6 x2 div1");
        run_quad(1, 0, 40, "R7 x1 div0");
        run_quad(1, 3, 30, "R7 x1 div3");

        // R8 illegal transition
        res_mode = 2'd3; presc_div = 8'd0;
        wait_n(10);
        pos = 0; expq = 0;
        idx = idx + 2;
        set_ab(gray(idx));
        idx = idx & 3;
        wait_n(20);
        check_eq("R8 error set", noise_err, 1);
        check_eq("R8 no count on illegal step", pos, 0);
        // R9 sticky, then clear
        for (int i = 0; i < 6; i++) qmove(i % 2);
        wait_n(10);
        check_eq("R9 error sticky", noise_err, 1);
        check_eq("R9 counting continues", pos, expq);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        wait_n(2);
        check_eq("R9 error cleared", noise_err, 0);

        // R10 enable gating
        count_en = 1'b0;
        wait_n(4);
        pos = 0; nstb = 0;
        for (int i = 0; i < 10; i++) qmove($urandom % 2);
        idx = idx + 2;
        set_ab(gray(idx));
        idx = idx & 3;
        wait_n(20);
        check_eq("R10 no strobe while disabled", nstb, 0);
        check_eq("R10 no error while disabled", noise_err, 0);
        count_en = 1'b1;
        wait_n(10);
        check_eq("R10 no spurious count on enable", nstb, 0);
        pos = 0; expq = 0;
        for (int i = 0; i < 8; i++) qmove($urandom % 2);
        wait_n(10);
        check_eq("R10 counting resumes", pos, expq);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule